// File: doc/BRIEF.md
# PLL Clock Controller

This block is the digital shell around an on-chip frequency-multiplying PLL. A static 4-bit clock-source select, set when the chip is configured, and a software enable bit must both agree before the PLL is switched on. A software low-speed bit halves the PLL reference, but the block refuses it while the PLL is the system clock source. A read-only lock flag reports lock only after the analog lock output has held for several reference cycles. Deep sleep modes force both the PLL and the oscillator off.

The analog PLL and the oscillator sit outside the block. Everything runs on one fast clock `clk`, the PLL output rate. The oscillator rate arrives as a one-cycle pulse, `osc_tick_i`. The system clock is produced as a one-cycle enable pulse, `sys_tick_o`, once per divided period. That period is the fast clock divided by four and then by a power-of-two prescaler. The divide-by-four step turns the nominal 64 MHz fast clock into a 16 MHz system clock.

Top module: `pll_clk_ctrl`

## Requirements
- R1: `pll_en_o` is 1 only when `cfg_sel_i` equals 4'b0001, the enable bit (`csr_rdata_o[0]`) is 1, and `sleep_mode_i` is not a deep mode. In every other case it is 0.
- R2: While `pll_en_o` is 1, `sys_tick_o` pulses exactly once every 4·2^N cycles of `clk`, where N is the prescale setting. While `pll_en_o` is 0, `sys_tick_o` stays 0.
- R3: The low-speed bit can be written through `csr_wdata_i[1]` when `cfg_sel_i` is not 4'b0001. It reads back on `csr_rdata_o[1]` and drives `ref_half_o` from the cycle after the write.
- R4: While `cfg_sel_i` equals 4'b0001, the low-speed bit stays 0, even after a write of 1.
- R5: With the reference undivided, the lock flag (`csr_rdata_o[2]`) becomes 1 after the 4th `osc_tick_i` pulse that arrives while `pll_lock_i` and `pll_en_o` are both 1. Fewer consecutive pulses leave it at 0.
- R6: The lock flag and the pulse count both clear one cycle after `pll_lock_i` falls or after `pll_en_o` falls.
- R7: Sleep modes 2 (power-down) and 3 (standby) force `pll_en_o` and `osc_en_o` to 0. Modes 0 (active) and 1 (idle) do not.
- R8: Prescale codes 0 to 8 written through `ps_we_i` appear on `ps_sel_o` one cycle later. Codes 9 to 15 are ignored and leave `ps_sel_o` unchanged.
- R9: A prescale change takes effect only at a period boundary. The period running when the write occurs completes at the old length, and the next period has the new length.
- R10: After reset the low-speed bit, the lock flag and `ps_sel_o` are 0. The enable bit is 1 if `cfg_sel_i` is 4'b0001 during reset and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock (PLL output rate) |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_sel_i | input | 4 | Static clock-source select; 4'b0001 selects the PLL |
| sleep_mode_i | input | 2 | 0 active, 1 idle, 2 power-down, 3 standby |
| csr_we_i | input | 1 | Control register write strobe |
| csr_wdata_i | input | 2 | [0] PLL enable, [1] low-speed bit |
| csr_rdata_o | output | 3 | [0] enable, [1] low-speed, [2] lock flag |
| ps_we_i | input | 1 | Prescale write strobe |
| ps_wdata_i | input | 4 | Prescale code N |
| ps_sel_o | output | 4 | Current prescale setting |
| osc_tick_i | input | 1 | One-cycle pulse per oscillator cycle |
| pll_lock_i | input | 1 | Raw lock indication from the PLL |
| pll_en_o | output | 1 | PLL enable to the analog macro |
| osc_en_o | output | 1 | Oscillator enable |
| ref_half_o | output | 1 | Selects the halved PLL reference |
| sys_tick_o | output | 1 | System clock enable pulse |

## Verification
The enable outputs are combinational from the registers and the inputs, so they are sampled 1 time unit after the edge at which they change. Register write results, and a lock flag set or cleared by an edge, appear at the sample that follows that edge. The bench checks each of them there.

Divider periods are measured as the number of sampled cycles between two `sys_tick_o` pulses and are compared with 4·2^N, which the bench computes itself. For each prescale change, the write is issued on the sample at which a tick is visible. The bench then requires one period at the old length before the new length starts.

// File: rtl/pllc_pkg.sv
package pllc_pkg;
    // 4-bit clock-source code that routes the PLL into the system clock
    localparam logic [3:0] SEL_PLL = 4'b0001;

    // positions in the control/status readback word
    localparam int CSR_EN   = 0;
    localparam int CSR_LSM  = 1;
    localparam int CSR_LOCK = 2;
    localparam int CSR_W    = 3;

    typedef enum logic [1:0] {
        SLP_ACTIVE = 2'd0,
        SLP_IDLE   = 2'd1,
        SLP_PDOWN  = 2'd2,
        SLP_STBY   = 2'd3
    } sleep_e;

    function automatic logic is_deep(input logic [1:0] mode);
        return (mode == SLP_PDOWN) || (mode == SLP_STBY);
    endfunction
endpackage

// File: rtl/pllc_csr.sv
module pllc_csr
    import pllc_pkg::*;
#(
    parameter int PS_W   = 4,
    parameter int PS_MAX = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [3:0]      cfg_sel_i,
    input  logic            we_i,
    input  logic [1:0]      wdata_i,
    input  logic            ps_we_i,
    input  logic [PS_W-1:0] ps_wdata_i,
    output logic            en_o,
    output logic            lsm_o,
    output logic [PS_W-1:0] ps_o
);
    typedef struct packed {
        logic            en;
        logic            lsm;
        logic [PS_W-1:0] ps;
    } csr_t;

    csr_t st_d, st_q;
    logic pll_is_sys;

    always_comb begin
        pll_is_sys = (cfg_sel_i == SEL_PLL);
        st_d = st_q;
        if (we_i) begin
            st_d.en  = wdata_i[0];
            st_d.lsm = wdata_i[1];
        end
        // halving the reference is refused while the PLL is the system clock
        if (pll_is_sys) st_d.lsm = 1'b0;
        if (ps_we_i && (ps_wdata_i <= PS_W'(PS_MAX))) st_d.ps = ps_wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.en  <= (cfg_sel_i == SEL_PLL);
            st_q.lsm <= 1'b0;
            st_q.ps  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign en_o  = st_q.en;
    assign lsm_o = st_q.lsm;
    assign ps_o  = st_q.ps;

    p_lsm_refused_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_sel_i == SEL_PLL) |=> !st_q.lsm);

    p_ps_reserved_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ps_we_i && (ps_wdata_i > PS_W'(PS_MAX))) |=> $stable(st_q.ps));

    p_ps_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ps <= PS_W'(PS_MAX));
endmodule

// File: rtl/pllc_lock.sv
module pllc_lock #(
    parameter int LOCK_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic lsm_i,
    input  logic osc_tick_i,
    input  logic lock_i,
    output logic locked_o
);
    localparam int CNT_W = (LOCK_CYC > 1) ? $clog2(LOCK_CYC) : 1;

    typedef struct packed {
        logic             half;
        logic [CNT_W-1:0] cnt;
        logic             flag;
    } lk_t;

    lk_t  st_d, st_q;
    logic ref_tick;

    always_comb begin
        st_d = st_q;
        // reference is the oscillator, or every second oscillator cycle
        ref_tick = osc_tick_i && (!lsm_i || st_q.half);
        if (!lsm_i)          st_d.half = 1'b0;
        else if (osc_tick_i) st_d.half = !st_q.half;

        if (!run_i || !lock_i) begin
            st_d.cnt  = '0;
            st_d.flag = 1'b0;
        end else if (ref_tick && !st_q.flag) begin
            if (st_q.cnt == CNT_W'(LOCK_CYC - 1)) st_d.flag = 1'b1;
            else                                  st_d.cnt  = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign locked_o = st_q.flag;

    p_lock_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i || !lock_i) |=> !locked_o);

    p_lock_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked_o) |-> ($past(lock_i) && $past(run_i) && $past(osc_tick_i)));
endmodule

// File: rtl/pllc_div.sv
module pllc_div #(
    parameter int PS_W     = 4,
    parameter int PS_MAX   = 8,
    parameter int PRE_LOG2 = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run_i,
    input  logic [PS_W-1:0] ps_i,
    output logic            tick_o
);
    localparam int CW = PRE_LOG2 + PS_MAX + 1;

    typedef struct packed {
        logic [CW-1:0]   cnt;
        logic [PS_W-1:0] n_act;
    } dv_t;

    dv_t           st_d, st_q;
    logic [CW-1:0] last;
    logic          wrap;

    always_comb begin
        st_d = st_q;
        last = (CW'(1) << (PRE_LOG2 + int'(st_q.n_act))) - CW'(1);
        wrap = run_i && (st_q.cnt == last);
        if (!run_i || wrap) begin
            // a new ratio is picked up only at a period boundary
            st_d.cnt   = '0;
            st_d.n_act = ps_i;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tick_o = wrap;

    p_no_tick_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |-> !tick_o);

    p_min_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);

    p_ratio_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !tick_o) |=> $stable(st_q.n_act));
endmodule

// File: rtl/pll_clk_ctrl.sv
module pll_clk_ctrl
    import pllc_pkg::*;
#(
    parameter int PS_W     = 4,
    parameter int PS_MAX   = 8,
    parameter int PRE_LOG2 = 2,
    parameter int LOCK_CYC = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       cfg_sel_i,
    input  logic [1:0]       sleep_mode_i,
    input  logic             csr_we_i,
    input  logic [1:0]       csr_wdata_i,
    output logic [CSR_W-1:0] csr_rdata_o,
    input  logic             ps_we_i,
    input  logic [PS_W-1:0]  ps_wdata_i,
    output logic [PS_W-1:0]  ps_sel_o,
    input  logic             osc_tick_i,
    input  logic             pll_lock_i,
    output logic             pll_en_o,
    output logic             osc_en_o,
    output logic             ref_half_o,
    output logic             sys_tick_o
);
    logic en_bit, lsm_bit, locked, deep, run;

    pllc_csr #(.PS_W(PS_W), .PS_MAX(PS_MAX)) u_csr (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_sel_i  (cfg_sel_i),
        .we_i       (csr_we_i),
        .wdata_i    (csr_wdata_i),
        .ps_we_i    (ps_we_i),
        .ps_wdata_i (ps_wdata_i),
        .en_o       (en_bit),
        .lsm_o      (lsm_bit),
        .ps_o       (ps_sel_o)
    );

    always_comb begin
        deep = is_deep(sleep_mode_i);
        run  = en_bit && (cfg_sel_i == SEL_PLL) && !deep;
    end

    pllc_lock #(.LOCK_CYC(LOCK_CYC)) u_lock (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_i      (run),
        .lsm_i      (lsm_bit),
        .osc_tick_i (osc_tick_i),
        .lock_i     (pll_lock_i),
        .locked_o   (locked)
    );

    pllc_div #(.PS_W(PS_W), .PS_MAX(PS_MAX), .PRE_LOG2(PRE_LOG2)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (run),
        .ps_i   (ps_sel_o),
        .tick_o (sys_tick_o)
    );

    always_comb begin
        csr_rdata_o           = '0;
        csr_rdata_o[CSR_EN]   = en_bit;
        csr_rdata_o[CSR_LSM]  = lsm_bit;
        csr_rdata_o[CSR_LOCK] = locked;
    end

    assign pll_en_o   = run;
    assign osc_en_o   = !deep;
    assign ref_half_o = lsm_bit;

    p_sleep_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_mode_i[1]) |-> (!pll_en_o && !osc_en_o && !sys_tick_o));

    p_pll_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
        pll_en_o |-> (cfg_sel_i == SEL_PLL && csr_rdata_o[CSR_EN]));

    p_lock_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !pll_en_o |=> !csr_rdata_o[CSR_LOCK]);
endmodule

// File: tb/pll_clk_ctrl_bench.sv
module pll_clk_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] cfg_sel = 4'b0000;
    logic [1:0] sleep_mode = 2'd0;
    logic       csr_we = 1'b0;
    logic [1:0] csr_wdata = 2'b00;
    logic [2:0] csr_rdata;
    logic       ps_we = 1'b0;
    logic [3:0] ps_wdata = 4'd0;
    logic [3:0] ps_sel;
    logic       osc_tick = 1'b0;
    logic       pll_lock = 1'b0;
    logic       pll_en, osc_en, ref_half, sys_tick;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    pll_clk_ctrl u_pll_clk_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_sel_i    (cfg_sel),
        .sleep_mode_i (sleep_mode),
        .csr_we_i     (csr_we),
        .csr_wdata_i  (csr_wdata),
        .csr_rdata_o  (csr_rdata),
        .ps_we_i      (ps_we),
        .ps_wdata_i   (ps_wdata),
        .ps_sel_o     (ps_sel),
        .osc_tick_i   (osc_tick),
        .pll_lock_i   (pll_lock),
        .pll_en_o     (pll_en),
        .osc_en_o     (osc_en),
        .ref_half_o   (ref_half),
        .sys_tick_o   (sys_tick)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic csr_write(input logic [1:0] v);
        csr_we = 1'b1; csr_wdata = v;
        step();
        csr_we = 1'b0;
    endtask

    task automatic do_reset(input logic [3:0] sel);
        cfg_sel = sel;
        rst_n = 1'b0;
        step(); step();
        rst_n = 1'b1;
        step();
    endtask

    // one oscillator pulse followed by two idle cycles
    task automatic osc_pulse();
        osc_tick = 1'b1;
        step();
        osc_tick = 1'b0;
        step(); step();
    endtask

    // cycles until sys_tick is seen; ends on a tick sample
    task automatic until_tick(output int n);
        n = 0;
        do begin
            step();
            n++;
        end while (!sys_tick && n < 5000);
    endtask

    initial begin
        int n;
        int cnt;
        int old_n;
        step();

        // R10 reset state with a non-PLL source
        do_reset(4'b0000);
        check("R10 en bit", csr_rdata[0], 0);
        check("R10 lsm bit", csr_rdata[1], 0);
        check("R10 lock flag", csr_rdata[2], 0);
        check("R10 prescale", ps_sel, 0);

        // R3 low-speed bit writable when PLL is not the system source
        csr_write(2'b10);
        check("R3 lsm readback", csr_rdata[1], 1);
        check("R3 ref_half", ref_half, 1);
        // R1 enable bit alone is not enough without select 0001
        csr_write(2'b11);
        check("R1 select gate", pll_en, 0);
        csr_write(2'b00);
        check("R3 lsm cleared", ref_half, 0);

        // R10 reset with PLL source: enable reads 1
        do_reset(4'b0001);
        check("R10 en bit with pll select", csr_rdata[0], 1);
        check("R1 pll on", pll_en, 1);
        // R4 low-speed write refused
        csr_write(2'b11);
        check("R4 lsm refused", csr_rdata[1], 0);
        check("R4 ref_half", ref_half, 0);
        // R1 clearing software bit turns PLL off
        csr_write(2'b00);
        check("R1 en bit off", pll_en, 0);
        // R2 no ticks while off
        cnt = 0;
        for (int i = 0; i < 60; i++) begin step(); if (sys_tick) cnt++; end
        check("R2 no tick when off", cnt, 0);
        csr_write(2'b01);
        check("R1 en bit on", pll_en, 1);

        // R7 sleep modes
        for (int m = 0; m < 4; m++) begin
            sleep_mode = m[1:0];
            #1;
            check($sformatf("R7 pll_en mode %0d", m), pll_en, (m >= 2) ? 0 : 1);
            check($sformatf("R7 osc_en mode %0d", m), osc_en, (m >= 2) ? 0 : 1);
        end
        sleep_mode = 2'd0;
        step();

        // R5 lock qualification
        pll_lock = 1'b1;
        for (int k = 1; k <= 3; k++) begin
            osc_pulse();
            check($sformatf("R5 flag after %0d pulses", k), csr_rdata[2], 0);
        end
        osc_pulse();
        check("R5 flag after 4 pulses", csr_rdata[2], 1);
        // R6 drop of lock input
        pll_lock = 1'b0;
        step();
        check("R6 flag cleared by lock drop", csr_rdata[2], 0);
        // R6 count restarts: 2 pulses, drop, 3 pulses -> still 0
        pll_lock = 1'b1;
        osc_pulse(); osc_pulse();
        pll_lock = 1'b0; step(); pll_lock = 1'b1;
        osc_pulse(); osc_pulse(); osc_pulse();
        check("R6 count restarted", csr_rdata[2], 0);
        osc_pulse();
        check("R5 flag after fresh 4", csr_rdata[2], 1);
        // R6 sleep drops the flag
        sleep_mode = 2'd3;
        step();
        check("R6 flag cleared by standby", csr_rdata[2], 0);
        sleep_mode = 2'd0;
        pll_lock = 1'b0;
        step();

        // R2 / R9 / R8 prescale sweep
        until_tick(n);
        until_tick(n);
        check("R2 period N=0", n, 4);
        old_n = 0;
        for (int p = 1; p <= 8; p++) begin
            // on a tick sample: write new code at the boundary edge
            ps_we = 1'b1; ps_wdata = p[3:0];
            step();
            ps_we = 1'b0;
            check($sformatf("R8 code %0d accepted", p), ps_sel, p);
            n = 1;
            while (!sys_tick && n < 5000) begin step(); n++; end
            check($sformatf("R9 old period kept at N=%0d", p), n, 4 << old_n);
            until_tick(n);
            check($sformatf("R2 period N=%0d", p), n, 4 << p);
            old_n = p;
        end
        // R9 write in the middle of a period
        ps_we = 1'b1; ps_wdata = 4'd1;
        step(); step(); step();
        ps_we = 1'b0;
        n = 3;
        while (!sys_tick && n < 5000) begin step(); n++; end
        check("R9 mid-period write keeps old length", n, 4 << 8);
        until_tick(n);
        check("R9 new length after boundary", n, 8);
        // R8 reserved codes
        for (int c = 9; c < 16; c++) begin
            ps_we = 1'b1; ps_wdata = c[3:0];
            step();
            ps_we = 1'b0;
            check($sformatf("R8 code %0d ignored", c), ps_sel, 1);
        end
        until_tick(n);
        until_tick(n);
        check("R8 period unchanged after reserved codes", n, 8);

        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule